// File: doc/BRIEF.md
# Serial programming command processor

This block sits behind the byte layer of a serial programming link. It takes command bytes from an external programmer, decodes them and carries them out against three byte-wide address spaces: a 16-bit data space, a small I/O space and a control/status space. For commands that read memory, the result goes back to the programmer as a response byte on a transmit handshake.

The data space is reached only through a 16-bit pointer register. Indirect loads and stores use that pointer as the address, and may increment it after the access. Software loads the pointer one byte at a time with a dedicated command. The I/O and control/status spaces are addressed directly by bits carried in the opcode itself. A key command takes eight following bytes into a 64-bit key register and signals when the key is complete.

Every command other than the key command is one opcode byte followed by one operand byte. For writes, the programmer sends the operand. For reads, the block returns it. Each memory port is a simple strobe interface: read data is expected on the clock edge after the read strobe.

Top module: `sprog_cmd_engine`

## Requirements
- R1: After a synchronous active-high reset, rx_ready is 1 and tx_valid is 0. The pointer is 0, so ds_addr reads 0. key_out is 0, key_valid is 0, and no read or write strobe is active.
- R2: Opcode 8'h20 reads the data space at the pointer address and returns the byte read as the response. The pointer is left unchanged.
- R3: Opcode 8'h24 reads the data space at the pointer address, returns the byte read, and then increments the pointer by one.
- R4: Opcodes 8'h60 and 8'h64 take one operand byte and write it to the data space at the pointer address. Only 8'h64 then increments the pointer.
- R5: Opcode 8'h68 writes its operand byte into pointer bits 7:0, and opcode 8'h69 writes it into bits 15:8. Neither causes a memory access.
- R6: An opcode of the form 0aa1_bbbb reads the I/O space at address {aa,bbbb} and returns the byte read.
- R7: An opcode of the form 1aa1_bbbb writes its operand byte to the I/O space at address {aa,bbbb}.
- R8: Opcode 1000_bbbb reads control/status address bbbb and returns the byte read. Opcode 1100_bbbb writes its operand byte to control/status address bbbb.
- R9: Opcode 8'hE0 takes the next 8 bytes as key data, with the first byte in key_out[7:0] and the last in key_out[63:56]. None of these bytes is decoded as a command. key_valid is high for exactly one cycle, the cycle after the eighth byte is accepted.
- R10: Any other opcode causes no memory access and no response, and the next byte received is decoded as a new command. At most one read or write strobe is active in any cycle.
- R11: The pointer wraps from 16'hFFFF to 16'h0000 on increment.
- R12: The read strobe is active in the cycle after the read command is accepted, and tx_valid rises two cycles after that. The response byte is held stable until tx_ready. rx_ready stays low while a response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received command or operand byte |
| rx_ready | output | 1 | Block accepts a received byte this cycle |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Link takes the response byte |
| ds_addr | output | 16 | Data space address (the pointer register) |
| ds_re | output | 1 | Data space read strobe |
| ds_we | output | 1 | Data space write strobe |
| ds_rdata | input | 8 | Data space read data, valid the cycle after ds_re |
| io_addr | output | 6 | I/O space address |
| io_re | output | 1 | I/O read strobe |
| io_we | output | 1 | I/O write strobe |
| io_rdata | input | 8 | I/O read data, valid the cycle after io_re |
| cs_addr | output | 4 | Control/status address |
| cs_re | output | 1 | Control/status read strobe |
| cs_we | output | 1 | Control/status write strobe |
| cs_rdata | input | 8 | Control/status read data, valid the cycle after cs_re |
| wr_data | output | 8 | Write data shared by all three spaces |
| key_out | output | 64 | Collected key |
| key_valid | output | 1 | One-cycle pulse when the key is complete |

## Verification
The bench builds the block with its default key length of eight bytes and the 16-bit pointer. Because the pointer can be written a byte at a time, it can be placed at 16'hFFFF in two commands, which puts the wraparound case within reach directly. The eight-byte key is long enough to include byte values that would decode as a load if they were taken as commands. A reset in the middle of a key also shows that the byte counter starts over.

// File: rtl/sprog_pkg.sv
`timescale 1ns/1ps
package sprog_pkg;
    localparam int BYTE_W    = 8;
    localparam int PTR_W     = 16;
    localparam int DIR_AW    = 6;
    localparam int CS_AW     = 4;
    localparam int PTR_BYTES = PTR_W / BYTE_W;

    typedef enum logic [3:0] {
        OPK_NONE,
        OPK_LOAD,
        OPK_STORE,
        OPK_PTRWR,
        OPK_IOIN,
        OPK_IOOUT,
        OPK_CSLOAD,
        OPK_CSSTORE,
        OPK_KEY
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic                post_inc;
        logic                byte_sel;
        logic [DIR_AW-1:0]   addr;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPND,
        ST_RDREQ,
        ST_RWAIT,
        ST_RESP,
        ST_WRITE,
        ST_KEY
    } eng_state_e;

    function automatic cmd_t decode_op(input logic [BYTE_W-1:0] op);
        cmd_t c;
        c = '{kind: OPK_NONE, post_inc: 1'b0, byte_sel: 1'b0, addr: '0};
        casez (op)
            8'b???1_????: begin
                c.kind = op[7] ? OPK_IOOUT : OPK_IOIN;
                c.addr = {op[6:5], op[3:0]};
            end
            8'b0010_0?00: begin
                c.kind     = OPK_LOAD;
                c.post_inc = op[2];
            end
            8'b0110_0?00: begin
                c.kind     = OPK_STORE;
                c.post_inc = op[2];
            end
            8'b0110_100?: begin
                c.kind     = OPK_PTRWR;
                c.byte_sel = op[0];
            end
            8'b1000_????: begin
                c.kind = OPK_CSLOAD;
                c.addr = {2'b00, op[3:0]};
            end
            8'b1100_????: begin
                c.kind = OPK_CSSTORE;
                c.addr = {2'b00, op[3:0]};
            end
            8'b1110_0000: c.kind = OPK_KEY;
            default:      c.kind = OPK_NONE;
        endcase
        return c;
    endfunction

    function automatic logic kind_reads(input op_kind_e k);
        return (k == OPK_LOAD) || (k == OPK_IOIN) || (k == OPK_CSLOAD);
    endfunction

    function automatic logic kind_takes_operand(input op_kind_e k);
        return (k == OPK_STORE) || (k == OPK_PTRWR) ||
               (k == OPK_IOOUT) || (k == OPK_CSSTORE);
    endfunction
endpackage

// File: rtl/sprog_op_decoder.sv
`timescale 1ns/1ps
module sprog_op_decoder
    import sprog_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output cmd_t              cmd
);
    always_comb begin
        cmd = decode_op(op);
    end
endmodule

// File: rtl/sprog_ptr_reg.sv
`timescale 1ns/1ps
module sprog_ptr_reg
    import sprog_pkg::*;
#(
    parameter int WIDTH = PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              inc,
    output logic [WIDTH-1:0]  ptr
);
    localparam int NBYTES = WIDTH / BYTE_W;

    logic [WIDTH-1:0] merged;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[b*BYTE_W +: BYTE_W] =
            (int'(wr_sel) == b) ? wr_byte : ptr[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (inc) begin
            ptr <= ptr + WIDTH'(1);
        end else if (wr_en) begin
            ptr <= merged;
        end
    end
endmodule

// File: rtl/sprog_key_collector.sv
`timescale 1ns/1ps
module sprog_key_collector
    import sprog_pkg::*;
#(
    parameter int NBYTES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic                     last,
    output logic [NBYTES*BYTE_W-1:0] key,
    output logic                     key_valid
);
    localparam int KW    = NBYTES * BYTE_W;
    localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [CNT_W-1:0] count;

    assign last = stb && (count == CNT_W'(NBYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            key       <= '0;
            key_valid <= 1'b0;
        end else begin
            key_valid <= last;
            if (stb) begin
                key   <= {byte_in, key[KW-1:BYTE_W]};
                count <= last ? '0 : count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sprog_cmd_engine.sv
`timescale 1ns/1ps
module sprog_cmd_engine
    import sprog_pkg::*;
#(
    parameter int KEY_BYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_data,
    output logic                        rx_ready,
    output logic                        tx_valid,
    output logic [BYTE_W-1:0]           tx_data,
    input  logic                        tx_ready,
    output logic [PTR_W-1:0]            ds_addr,
    output logic                        ds_re,
    output logic                        ds_we,
    input  logic [BYTE_W-1:0]           ds_rdata,
    output logic [DIR_AW-1:0]           io_addr,
    output logic                        io_re,
    output logic                        io_we,
    input  logic [BYTE_W-1:0]           io_rdata,
    output logic [CS_AW-1:0]            cs_addr,
    output logic                        cs_re,
    output logic                        cs_we,
    input  logic [BYTE_W-1:0]           cs_rdata,
    output logic [BYTE_W-1:0]           wr_data,
    output logic [KEY_BYTES*BYTE_W-1:0] key_out,
    output logic                        key_valid
);
    eng_state_e         state, state_nxt;
    cmd_t               dec, cmd_q;
    logic [BYTE_W-1:0]  opnd_q, txbuf_q, rd_mux;
    logic               rx_take, key_stb, key_last;
    logic               ptr_inc, ptr_wr;
    logic [PTR_W-1:0]   ptr;

    sprog_op_decoder u_dec (
        .op  (rx_data),
        .cmd (dec)
    );

    assign rx_ready = (state == ST_IDLE) || (state == ST_OPND) || (state == ST_KEY);
    assign rx_take  = rx_valid && rx_ready;
    assign key_stb  = (state == ST_KEY) && rx_take;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (rx_take) begin
                if (kind_reads(dec.kind))              state_nxt = ST_RDREQ;
                else if (kind_takes_operand(dec.kind)) state_nxt = ST_OPND;
                else if (dec.kind == OPK_KEY)          state_nxt = ST_KEY;
            end
            ST_OPND:  if (rx_take)  state_nxt = ST_WRITE;
            ST_RDREQ: state_nxt = ST_RWAIT;
            ST_RWAIT: state_nxt = ST_RESP;
            ST_RESP:  if (tx_ready) state_nxt = ST_IDLE;
            ST_WRITE: state_nxt = ST_IDLE;
            ST_KEY:   if (key_last) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (cmd_q.kind)
            OPK_IOIN:   rd_mux = io_rdata;
            OPK_CSLOAD: rd_mux = cs_rdata;
            default:    rd_mux = ds_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cmd_q   <= '0;
            opnd_q  <= '0;
            txbuf_q <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && rx_take) cmd_q  <= dec;
            if (state == ST_OPND && rx_take) opnd_q <= rx_data;
            if (state == ST_RWAIT)           txbuf_q <= rd_mux;
        end
    end

    assign ds_re = (state == ST_RDREQ) && (cmd_q.kind == OPK_LOAD);
    assign io_re = (state == ST_RDREQ) && (cmd_q.kind == OPK_IOIN);
    assign cs_re = (state == ST_RDREQ) && (cmd_q.kind == OPK_CSLOAD);
    assign ds_we = (state == ST_WRITE) && (cmd_q.kind == OPK_STORE);
    assign io_we = (state == ST_WRITE) && (cmd_q.kind == OPK_IOOUT);
    assign cs_we = (state == ST_WRITE) && (cmd_q.kind == OPK_CSSTORE);

    assign ptr_wr  = (state == ST_WRITE) && (cmd_q.kind == OPK_PTRWR);
    assign ptr_inc = cmd_q.post_inc && (ds_re || ds_we);

    sprog_ptr_reg #(.WIDTH(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ptr_wr),
        .wr_sel  (cmd_q.byte_sel),
        .wr_byte (opnd_q),
        .inc     (ptr_inc),
        .ptr     (ptr)
    );

    sprog_key_collector #(.NBYTES(KEY_BYTES)) u_key (
        .clk       (clk),
        .rst       (rst),
        .stb       (key_stb),
        .byte_in   (rx_data),
        .last      (key_last),
        .key       (key_out),
        .key_valid (key_valid)
    );

    assign ds_addr  = ptr;
    assign io_addr  = cmd_q.addr;
    assign cs_addr  = cmd_q.addr[CS_AW-1:0];
    assign wr_data  = opnd_q;
    assign tx_valid = (state == ST_RESP);
    assign tx_data  = txbuf_q;
endmodule

// File: rtl/sprog_cmd_engine_chk.sv
`timescale 1ns/1ps
module sprog_cmd_engine_chk
    import sprog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] tx_data,
    input logic              ds_re,
    input logic              ds_we,
    input logic              io_re,
    input logic              io_we,
    input logic              cs_re,
    input logic              cs_we,
    input logic              key_valid
);
    p_rx_tx_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(rx_ready && tx_valid));

    p_tx_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_rd_to_resp_r12: assert property (@(posedge clk) disable iff (rst)
        (ds_re || io_re || cs_re) |=> ##1 tx_valid);

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ds_re, ds_we, io_re, io_we, cs_re, cs_we}));

    p_key_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    p_no_strobe_on_tx_r10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !(ds_re || ds_we || io_re || io_we || cs_re || cs_we));
endmodule

bind sprog_cmd_engine sprog_cmd_engine_chk chk_i (.*);

// File: tb/sprog_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module sprog_cmd_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic [15:0] ds_addr;
    logic        ds_re, ds_we;
    logic [7:0]  ds_rdata = 8'h00;
    logic [5:0]  io_addr;
    logic        io_re, io_we;
    logic [7:0]  io_rdata = 8'h00;
    logic [3:0]  cs_addr;
    logic        cs_re, cs_we;
    logic [7:0]  cs_rdata = 8'h00;
    logic [7:0]  wr_data;
    logic [63:0] key_out;
    logic        key_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sprog_cmd_engine #(.KEY_BYTES(8)) dut_i (.*);

    function automatic logic [7:0] f_ds(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] f_io(input logic [5:0] a);
        return {2'b01, a} ^ 8'hA5;
    endfunction
    function automatic logic [7:0] f_cs(input logic [3:0] a);
        return {4'h9, a};
    endfunction

    // memory models: read data appears on the edge after the strobe
    int          acc_cnt;
    logic [1:0]  lw_sp;
    logic [15:0] lw_addr;
    logic [7:0]  lw_data;
    always @(posedge clk) begin
        ds_rdata <= ds_re ? f_ds(ds_addr) : 8'hEE;
        io_rdata <= io_re ? f_io(io_addr) : 8'hEE;
        cs_rdata <= cs_re ? f_cs(cs_addr) : 8'hEE;
        if (rst) begin
            acc_cnt <= 0;
            lw_sp   <= 2'd3;
            lw_addr <= 16'h0;
            lw_data <= 8'h0;
        end else begin
            if (ds_re | ds_we | io_re | io_we | cs_re | cs_we) acc_cnt <= acc_cnt + 1;
            if (ds_we) begin
                lw_sp <= 2'd0; lw_addr <= ds_addr; lw_data <= wr_data;
            end else if (io_we) begin
                lw_sp <= 2'd1; lw_addr <= {10'd0, io_addr}; lw_data <= wr_data;
            end else if (cs_we) begin
                lw_sp <= 2'd2; lw_addr <= {12'd0, cs_addr}; lw_data <= wr_data;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic get_resp(output logic [7:0] d);
        while (!tx_valid) @(negedge clk);
        d = tx_data;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    function automatic string tag_of(input logic [7:0] op);
        if (op[4]) return op[7] ? "R7" : "R6";
        casez (op)
            8'b0010_0000: return "R2";
            8'b0010_0100: return "R3";
            8'b0110_0?00: return "R4";
            8'b0110_100?: return "R5";
            default:      return "R8";
        endcase
    endfunction

    // {cmd, operand, is_read, space(0 ds,1 io,2 cs,3 none), pad, addr, pointer after}
    localparam int NV = 14;
    localparam logic [55:0] VEC [NV] = '{
        {8'h68, 8'h34, 1'b0, 2'd3, 5'd0, 16'h0000, 16'h0034},
        {8'h69, 8'h12, 1'b0, 2'd3, 5'd0, 16'h0000, 16'h1234},
        {8'h20, 8'h00, 1'b1, 2'd0, 5'd0, 16'h1234, 16'h1234},
        {8'h24, 8'h00, 1'b1, 2'd0, 5'd0, 16'h1234, 16'h1235},
        {8'h60, 8'hA7, 1'b0, 2'd0, 5'd0, 16'h1235, 16'h1235},
        {8'h64, 8'h5E, 1'b0, 2'd0, 5'd0, 16'h1235, 16'h1236},
        {8'h24, 8'h00, 1'b1, 2'd0, 5'd0, 16'h1236, 16'h1237},
        {8'h7F, 8'h00, 1'b1, 2'd1, 5'd0, 16'h003F, 16'h1237},
        {8'h12, 8'h00, 1'b1, 2'd1, 5'd0, 16'h0002, 16'h1237},
        {8'hB5, 8'hC3, 1'b0, 2'd1, 5'd0, 16'h0015, 16'h1237},
        {8'hF0, 8'h0F, 1'b0, 2'd1, 5'd0, 16'h0030, 16'h1237},
        {8'h8A, 8'h00, 1'b1, 2'd2, 5'd0, 16'h000A, 16'h1237},
        {8'hC3, 8'h99, 1'b0, 2'd2, 5'd0, 16'h0003, 16'h1237},
        {8'h80, 8'h00, 1'b1, 2'd2, 5'd0, 16'h0000, 16'h1237}
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, d0;
        int n0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {rx_ready, tx_valid, key_valid}, 3'b100);
        chk("R1", ds_addr, 16'h0000);
        chk("R1", key_out, 64'h0);
        chk("R1", acc_cnt, 0);

        for (int i = 0; i < NV; i++) begin
            logic [55:0] v;
            logic [7:0]  cmd, wb;
            logic [1:0]  sp;
            logic [15:0] ad, pa;
            string       tg;
            v = VEC[i];
            cmd = v[55:48]; wb = v[47:40]; sp = v[38:37];
            ad = v[31:16]; pa = v[15:0];
            tg = tag_of(cmd);
            n0 = acc_cnt;
            send(cmd);
            if (v[39]) begin
                case (sp)
                    2'd0:    chk(tg, {ds_re, ds_addr}, {1'b1, ad});
                    2'd1:    chk(tg, {io_re, io_addr}, {1'b1, ad[5:0]});
                    default: chk(tg, {cs_re, cs_addr}, {1'b1, ad[3:0]});
                endcase
                get_resp(d);
                case (sp)
                    2'd0:    chk(tg, d, f_ds(ad));
                    2'd1:    chk(tg, d, f_io(ad[5:0]));
                    default: chk(tg, d, f_cs(ad[3:0]));
                endcase
            end else begin
                send(wb);
                @(negedge clk);
                if (sp == 2'd3) chk(tg, acc_cnt - n0, 0);
                else            chk(tg, {lw_sp, lw_addr, lw_data}, {sp, ad, wb});
            end
            @(negedge clk);
            chk(tg, ds_addr, pa);
        end

        // R12: strobe timing, response held until taken, no byte accepted meanwhile
        send(8'h20);
        chk("R12", ds_re, 1'b1);
        @(negedge clk);
        chk("R12", {ds_re, tx_valid}, 2'b00);
        @(negedge clk);
        chk("R12", {tx_valid, rx_ready}, 2'b10);
        d0 = tx_data;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R12", {tx_valid, rx_ready, tx_data}, {1'b1, 1'b0, d0});
        end
        get_resp(d);
        chk("R12", d, f_ds(16'h1237));

        // R11: wrap at the top of the pointer range
        send(8'h68); send(8'hFF);
        send(8'h69); send(8'hFF);
        @(negedge clk);
        chk("R11", ds_addr, 16'hFFFF);
        send(8'h24);
        get_resp(d);
        chk("R11", d, f_ds(16'hFFFF));
        @(negedge clk);
        chk("R11", ds_addr, 16'h0000);

        // R10: unknown opcodes do nothing, next byte is a fresh command
        n0 = acc_cnt;
        send(8'h00); send(8'hE1); send(8'h21); send(8'h6A);
        repeat (2) @(negedge clk);
        chk("R10", acc_cnt - n0, 0);
        chk("R10", {rx_ready, tx_valid}, 2'b10);
        chk("R10", ds_addr, 16'h0000);
        send(8'h20);
        chk("R10", ds_re, 1'b1);
        get_resp(d);
        chk("R10", d, f_ds(16'h0000));

        // R1 reset in the middle of a key, with a nonzero pointer
        send(8'h68); send(8'hAB);
        send(8'hE0); send(8'h01); send(8'h02); send(8'h03);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {rx_ready, tx_valid, key_valid}, 3'b100);
        chk("R1", ds_addr, 16'h0000);
        chk("R1", key_out, 64'h0);

        // R9: key bytes including values that look like load opcodes
        n0 = acc_cnt;
        send(8'hE0);
        send(8'h20); send(8'h11); send(8'h22); send(8'h33);
        send(8'h44); send(8'h55); send(8'h66);
        chk("R9", key_valid, 1'b0);
        send(8'h24);
        chk("R9", key_valid, 1'b1);
        chk("R9", key_out, 64'h2466554433221120);
        @(negedge clk);
        chk("R9", key_valid, 1'b0);
        chk("R9", {rx_ready, tx_valid}, 2'b10);
        chk("R9", acc_cnt - n0, 0);
        send(8'h20);
        get_resp(d);
        chk("R9", d, f_ds(16'h0000));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule